// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This unit produces the fetch address for a small 8-bit controller. It holds an 11-bit program counter over a 2K-word program store. The store is split into two 1K-word pages: bit 10 is the page bit and bits 9:0 are the offset within the page. A one-bit page-select register supplies the page bit for absolute jumps and calls. Software sets that register through a dedicated write strobe.

Each clock is one instruction cycle. In each cycle the external decoder presents one operation code, together with the instruction's 10-bit immediate and the current accumulator and status bytes. The unit then updates the counter. It keeps a 16-slot ring of return addresses. It also keeps a three-byte shadow copy of accumulator, status and page, which is taken on interrupt entry and handed back on return-from-interrupt.

Top module: `prog_addr_unit`

## Requirements
- R1: After reset the fetch address is 0x000 and the page register is 0. A return (op=3) issued straight after reset yields 0x000.
- R2: With op=0 (or any unused code 10..15), the offset bits 9:0 increment by one and bit 10 is held, so 0x7FF is followed by 0x400.
- R3: A jump (op=1) sets the address to {page register, imm}.
- R4: A call (op=2) pushes {bit 10, offset+1} onto the ring and then jumps like op=1. A call at offset 0x3FF pushes offset 0x000 of the same page.
- R5: Return (op=3), return-with-literal (op=4) and return-from-interrupt (op=5) each load the address from the newest ring entry and remove that entry, so nested calls unwind in reverse order.
- R6: Accumulator move (op=6) sets bits 7:0 to the accumulator, clears bits 9:8 and keeps bit 10.
- R7: Accumulator add (op=7) sets bits 7:0 to (bits 7:0 + accumulator) mod 256, clears bits 9:8 and keeps bit 10.
- R8: Table add (op=8) sets bits 7:0 to (bits 7:0 + accumulator) mod 256. It keeps bits 10:8 unchanged, and the carry out of bit 7 is dropped.
- R9: Interrupt entry (op=9) pushes the current address unchanged, saves accumulator, status and page into the shadow store, clears the page register and sets the address to {0, IRQ_VEC} (default 0x008).
- R10: In the cycle op=5 is presented, restore_en is 1 and restore_acc/restore_stat show the saved bytes. After that edge the page register holds the saved page. restore_en is 0 for every other op.
- R11: The ring never flags misuse. A push onto 16 held entries overwrites the oldest one, and pops keep circling. After 17 calls, 16 returns give return addresses 17 down to 2, and a 17th return gives return address 17 again.
- R12: page_we=1 loads page_in into the page register for later jumps and calls. On op=9 or op=5, the interrupt and restore updates take precedence over page_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code (0 step, 1 jump, 2 call, 3 return, 4 return-literal, 5 return-interrupt, 6 acc move, 7 acc add, 8 table add, 9 interrupt) |
| imm | input | 10 | In-page target from the instruction |
| acc | input | 8 | Current accumulator |
| status | input | 8 | Current status byte |
| page_we | input | 1 | Page register write strobe |
| page_in | input | 1 | Page value to write |
| pc_addr | output | 11 | Registered fetch address |
| restore_en | output | 1 | Shadow bytes valid for write-back this cycle |
| restore_acc | output | 8 | Saved accumulator |
| restore_stat | output | 8 | Saved status |

## Verification
The assertions check every cycle, one cycle after each operation, how the address relates to its previous value. This covers in-page increment, the jump composition, cleared or kept bits 9:8 for the three accumulator forms, the interrupt vector, the ring pointer moving on pushes and pops, and the page write. Only the bench scenarios can show that returned addresses come back in last-in order, that an overwritten ring returns the expected values, and that the shadow bytes and page survive an interrupt body that changes them.

// File: rtl/pau_pkg.sv
package pau_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_STEP   = 4'd0,
        OP_JMP    = 4'd1,
        OP_CALL   = 4'd2,
        OP_RET    = 4'd3,
        OP_RETL   = 4'd4,
        OP_RETI   = 4'd5,
        OP_ACCMOV = 4'd6,
        OP_ACCADD = 4'd7,
        OP_TBLADD = 4'd8,
        OP_IRQ    = 4'd9
    } pau_op_e;

endpackage

// File: rtl/pau_next_pc.sv
module pau_next_pc
    import pau_pkg::*;
#(
    parameter int               OFFW    = 10,
    parameter int               DW      = 8,
    parameter logic [OFFW-1:0]  IRQ_VEC = 10'h008
) (
    input  pau_op_e             op,
    input  logic [OFFW:0]       pc_q,
    input  logic                page_q,
    input  logic [OFFW-1:0]     imm,
    input  logic [DW-1:0]       acc,
    input  logic [OFFW:0]       tos,
    output logic [OFFW:0]       pc_d,
    output logic                push,
    output logic                pop,
    output logic [OFFW:0]       push_val,
    output logic                save,
    output logic                restore
);

    localparam int HIW = OFFW - DW;

    logic [DW-1:0]   low_sum;
    logic [OFFW-1:0] off_inc;

    always_comb begin
        low_sum  = pc_q[DW-1:0] + acc;
        off_inc  = pc_q[OFFW-1:0] + 1'b1;
        pc_d     = {pc_q[OFFW], off_inc};
        push     = 1'b0;
        pop      = 1'b0;
        push_val = {pc_q[OFFW], off_inc};
        save     = 1'b0;
        restore  = 1'b0;
        case (op)
            OP_JMP: begin
                pc_d = {page_q, imm};
            end
            OP_CALL: begin
                push = 1'b1;
                pc_d = {page_q, imm};
            end
            OP_RET, OP_RETL: begin
                pop  = 1'b1;
                pc_d = tos;
            end
            OP_RETI: begin
                pop     = 1'b1;
                restore = 1'b1;
                pc_d    = tos;
            end
            OP_ACCMOV: begin
                pc_d = {pc_q[OFFW], {HIW{1'b0}}, acc};
            end
            OP_ACCADD: begin
                pc_d = {pc_q[OFFW], {HIW{1'b0}}, low_sum};
            end
            OP_TBLADD: begin
                pc_d = {pc_q[OFFW], pc_q[OFFW-1:DW], low_sum};
            end
            OP_IRQ: begin
                push     = 1'b1;
                push_val = pc_q;
                save     = 1'b1;
                pc_d     = {1'b0, IRQ_VEC};
            end
            default: begin
                pc_d = {pc_q[OFFW], off_inc};
            end
        endcase
    end

endmodule

// File: rtl/pau_ret_stack.sv
module pau_ret_stack #(
    parameter int AW    = 11,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [AW-1:0]              push_val,
    output logic [AW-1:0]              tos,
    output logic [$clog2(DEPTH)-1:0]   sp
);

    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [PW-1:0]              sp;
        logic [DEPTH-1:0][AW-1:0]   slots;
    } stk_t;

    stk_t          st_d, st_q;
    logic [PW-1:0] below;

    always_comb begin
        below = st_q.sp - 1'b1;
        st_d  = st_q;
        if (push) begin
            st_d.slots[st_q.sp] = push_val;
            st_d.sp             = st_q.sp + 1'b1;
        end else if (pop) begin
            st_d.sp = below;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tos = st_q.slots[below];
    assign sp  = st_q.sp;

endmodule

// File: rtl/pau_irq_shadow.sv
module pau_irq_shadow #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] stat_in,
    input  logic          page_in,
    output logic [DW-1:0] acc_out,
    output logic [DW-1:0] stat_out,
    output logic          page_out
);

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] stat;
        logic          page;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (save) begin
            sh_d.acc  = acc_in;
            sh_d.stat = stat_in;
            sh_d.page = page_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign acc_out  = sh_q.acc;
    assign stat_out = sh_q.stat;
    assign page_out = sh_q.page;

endmodule

// File: rtl/prog_addr_unit.sv
module prog_addr_unit
    import pau_pkg::*;
#(
    parameter int               OFFW    = 10,
    parameter int               DW      = 8,
    parameter int               DEPTH   = 16,
    parameter logic [OFFW-1:0]  IRQ_VEC = 10'h008
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      op,
    input  logic [OFFW-1:0] imm,
    input  logic [DW-1:0]   acc,
    input  logic [DW-1:0]   status,
    input  logic            page_we,
    input  logic            page_in,
    output logic [OFFW:0]   pc_addr,
    output logic            restore_en,
    output logic [DW-1:0]   restore_acc,
    output logic [DW-1:0]   restore_stat
);

    localparam int AW = OFFW + 1;
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic          page;
    } core_t;

    core_t         core_d, core_q;
    pau_op_e       op_dec;
    logic [AW-1:0] pc_next;
    logic          stk_push, stk_pop, sh_save, sh_restore, sh_page;
    logic [AW-1:0] stk_push_val, stk_tos;
    logic [PW-1:0] stk_sp;
    logic          page_q;

    assign op_dec = pau_op_e'(op);
    assign page_q = core_q.page;

    pau_next_pc #(
        .OFFW    (OFFW),
        .DW      (DW),
        .IRQ_VEC (IRQ_VEC)
    ) u_next (
        .op       (op_dec),
        .pc_q     (core_q.pc),
        .page_q   (core_q.page),
        .imm      (imm),
        .acc      (acc),
        .tos      (stk_tos),
        .pc_d     (pc_next),
        .push     (stk_push),
        .pop      (stk_pop),
        .push_val (stk_push_val),
        .save     (sh_save),
        .restore  (sh_restore)
    );

    pau_ret_stack #(
        .AW    (AW),
        .DEPTH (DEPTH)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (stk_push),
        .pop      (stk_pop),
        .push_val (stk_push_val),
        .tos      (stk_tos),
        .sp       (stk_sp)
    );

    pau_irq_shadow #(
        .DW (DW)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .save     (sh_save),
        .acc_in   (acc),
        .stat_in  (status),
        .page_in  (core_q.page),
        .acc_out  (restore_acc),
        .stat_out (restore_stat),
        .page_out (sh_page)
    );

    always_comb begin
        core_d    = core_q;
        core_d.pc = pc_next;
        if (sh_save) begin
            core_d.page = 1'b0;
        end else if (sh_restore) begin
            core_d.page = sh_page;
        end else if (page_we) begin
            core_d.page = page_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign pc_addr    = core_q.pc;
    assign restore_en = sh_restore;

endmodule

// File: rtl/pau_checker.sv
module pau_checker #(
    parameter int               OFFW    = 10,
    parameter int               DW      = 8,
    parameter int               PW      = 4,
    parameter logic [OFFW-1:0]  IRQ_VEC = 10'h008
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      op,
    input logic [OFFW-1:0] imm,
    input logic [DW-1:0]   acc,
    input logic            page_we,
    input logic            page_in,
    input logic [OFFW:0]   pc_addr,
    input logic            restore_en,
    input logic            page_q,
    input logic [PW-1:0]   stk_sp
);

    p_reset_pc_r1: assert property (@(posedge clk)
        !rst_n |=> (pc_addr == '0) && !page_q);

    p_step_in_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd0) |=> pc_addr == {$past(pc_addr[OFFW]), $past(pc_addr[OFFW-1:0]) + 1'b1});

    p_jump_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd1) |=> pc_addr == {$past(page_q), $past(imm)});

    p_call_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd2) |=> (stk_sp == $past(stk_sp) + 1'b1) && (pc_addr[OFFW-1:0] == $past(imm)));

    p_return_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == 4'd3) || (op == 4'd4) || (op == 4'd5)) |=> stk_sp == $past(stk_sp) - 1'b1);

    p_accmov_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd6) |=> (pc_addr[OFFW-1:DW] == '0) && (pc_addr[DW-1:0] == $past(acc))
                          && (pc_addr[OFFW] == $past(pc_addr[OFFW])));

    p_accadd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd7) |=> (pc_addr[OFFW-1:DW] == '0) && (pc_addr[OFFW] == $past(pc_addr[OFFW])));

    p_table_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd8) |=> pc_addr[OFFW:DW] == $past(pc_addr[OFFW:DW]));

    p_irq_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd9) |=> (pc_addr == {1'b0, IRQ_VEC}) && !page_q
                          && (stk_sp == $past(stk_sp) + 1'b1));

    p_restore_only_reti_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |-> (op == 4'd5));

    p_reti_restores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd5) |-> restore_en);

    p_page_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (page_we && (op != 4'd5) && (op != 4'd9)) |=> page_q == $past(page_in));

endmodule

bind prog_addr_unit pau_checker #(
    .OFFW    (OFFW),
    .DW      (DW),
    .PW      ($clog2(DEPTH)),
    .IRQ_VEC (IRQ_VEC)
) i_pau_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .imm        (imm),
    .acc        (acc),
    .page_we    (page_we),
    .page_in    (page_in),
    .pc_addr    (pc_addr),
    .restore_en (restore_en),
    .page_q     (page_q),
    .stk_sp     (stk_sp)
);

// File: tb/test_prog_addr_unit.sv
`timescale 1ns/1ps
module test_prog_addr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = '0;
    logic [9:0]  imm = '0;
    logic [7:0]  acc = '0;
    logic [7:0]  status = '0;
    logic        page_we = 1'b0;
    logic        page_in = 1'b0;
    logic [10:0] pc_addr;
    logic        restore_en;
    logic [7:0]  restore_acc;
    logic [7:0]  restore_stat;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prog_addr_unit i_prog_addr_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .op           (op),
        .imm          (imm),
        .acc          (acc),
        .status       (status),
        .page_we      (page_we),
        .page_in      (page_in),
        .pc_addr      (pc_addr),
        .restore_en   (restore_en),
        .restore_acc  (restore_acc),
        .restore_stat (restore_stat)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op = '0; imm = '0; acc = '0; status = '0;
        page_we = 1'b0; page_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input logic [3:0] o, input logic [9:0] i, input logic [7:0] a,
                         input logic [7:0] s, input logic pw, input logic pv);
        op = o; imm = i; acc = a; status = s; page_we = pw; page_in = pv;
        @(negedge clk);
        page_we = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 pc after reset", 32'(pc_addr), 32'h000);
        issue(4'd3, 10'h0, 8'h0, 8'h0, 1'b0, 1'b0);
        chk("R1 return on empty ring", 32'(pc_addr), 32'h000);
        issue(4'd1, 10'h155, 8'h0, 8'h0, 1'b0, 1'b0);
        chk("R1 page reg zero after reset", 32'(pc_addr), 32'h155);
    endtask

    task automatic t_step_page();
        do_reset();
        issue(4'd0, 10'h0, 8'h0, 8'h0, 1'b1, 1'b1);
        chk("R2 step keeps page bit", 32'(pc_addr), 32'h001);
        issue(4'd1, 10'h3FE, 8'h0, 8'h0, 1'b0, 1'b0);
        chk("R3 R12 jump uses page reg", 32'(pc_addr), 32'h7FE);
        issue(4'd0, 10'h0, 8'h0, 8'h0, 1'b0, 1'b0);
        chk("R2 step", 32'(pc_addr), 32'h7FF);
        issue(4'd0, 10'h0, 8'h0, 8'h0, 1'b0, 1'b0);
        chk("R2 wrap inside page", 32'(pc_addr), 32'h400);
        issue(4'd12, 10'h0, 8'h0, 8'h0, 1'b0, 1'b0);
        chk("R2 unused code steps", 32'(pc_addr), 32'h401);
        issue(4'd1, 10'h020, 8'h0, 8'h0, 1'b1, 1'b0);
        chk("R12 write same cycle as jump not seen yet", 32'(pc_addr), 32'h420);
        issue(4'd1, 10'h020, 8'h0, 8'h0, 1'b0, 1'b0);
        chk("R12 page cleared by write", 32'(pc_addr), 32'h020);
    endtask

    task automatic t_call_ret();
        do_reset();
        issue(4'd1, 10'h100, 8'h0, 8'h0, 1'b0, 1'b0);
        issue(4'd2, 10'h200, 8'h0, 8'h0, 1'b0, 1'b0);
        chk("R4 call target", 32'(pc_addr), 32'h200);
        issue(4'd2, 10'h300, 8'h0, 8'h0, 1'b0, 1'b0);
        chk("R4 nested call target", 32'(pc_addr), 32'h300);
        issue(4'd4, 10'h0, 8'h0, 8'h0, 1'b0, 1'b0);
        chk("R5 return-literal inner", 32'(pc_addr), 32'h201);
        issue(4'd3, 10'h0, 8'h0, 8'h0, 1'b0, 1'b0);
        chk("R5 return outer", 32'(pc_addr), 32'h101);
        issue(4'd1, 10'h3FF, 8'h0, 8'h0, 1'b0, 1'b0);
        issue(4'd2, 10'h050, 8'h0, 8'h0, 1'b0, 1'b0);
        issue(4'd3, 10'h0, 8'h0, 8'h0, 1'b0, 1'b0);
        chk("R4 call at page end returns to offset 0", 32'(pc_addr), 32'h000);
    endtask

    task automatic t_acc_forms();
        do_reset();
        issue(4'd0, 10'h0, 8'h0, 8'h0, 1'b1, 1'b1);
        issue(4'd1, 10'h3F0, 8'h0, 8'h0, 1'b0, 1'b0);
        issue(4'd6, 10'h0, 8'h5A, 8'h0, 1'b0, 1'b0);
        chk("R6 acc move clears bits 9:8", 32'(pc_addr), 32'h45A);
        issue(4'd1, 10'h2F0, 8'h0, 8'h0, 1'b0, 1'b0);
        issue(4'd7, 10'h0, 8'h20, 8'h0, 1'b0, 1'b0);
        chk("R7 acc add wraps and clears bits 9:8", 32'(pc_addr), 32'h410);
        issue(4'd1, 10'h2F0, 8'h0, 8'h0, 1'b0, 1'b0);
        issue(4'd8, 10'h0, 8'h20, 8'h0, 1'b0, 1'b0);
        chk("R8 table add keeps bits 9:8", 32'(pc_addr), 32'h610);
        issue(4'd8, 10'h0, 8'h05, 8'h0, 1'b0, 1'b0);
        chk("R8 table add no carry", 32'(pc_addr), 32'h615);
    endtask

    task automatic t_irq();
        do_reset();
        issue(4'd0, 10'h0, 8'h0, 8'h0, 1'b1, 1'b1);
        issue(4'd1, 10'h123, 8'h0, 8'h0, 1'b0, 1'b0);
        issue(4'd9, 10'h0, 8'h3C, 8'hA5, 1'b1, 1'b1);
        chk("R9 interrupt vector", 32'(pc_addr), 32'h008);
        issue(4'd1, 10'h055, 8'h11, 8'h22, 1'b0, 1'b0);
        chk("R9 R12 page cleared over page_we", 32'(pc_addr), 32'h055);
        chk("R10 no restore outside return-interrupt", 32'(restore_en), 32'h0);
        op = 4'd5; acc = 8'h77; status = 8'h66; page_we = 1'b1; page_in = 1'b0;
        #1;
        chk("R10 restore_en", 32'(restore_en), 32'h1);
        chk("R10 restore_acc", 32'(restore_acc), 32'h3C);
        chk("R10 restore_stat", 32'(restore_stat), 32'hA5);
        @(negedge clk);
        page_we = 1'b0;
        chk("R5 R10 return from interrupt", 32'(pc_addr), 32'h523);
        issue(4'd1, 10'h001, 8'h0, 8'h0, 1'b0, 1'b0);
        chk("R10 page restored", 32'(pc_addr), 32'h401);
    endtask

    task automatic t_ring_wrap();
        logic [10:0] ret [17];
        logic [10:0] cur;
        do_reset();
        cur = 11'h000;
        for (int i = 0; i < 17; i++) begin
            ret[i] = {cur[10], cur[9:0] + 10'd1};
            cur    = 11'(10 * (i + 1));
            issue(4'd2, 10'(10 * (i + 1)), 8'h0, 8'h0, 1'b0, 1'b0);
        end
        chk("R11 last call target", 32'(pc_addr), 32'(cur));
        for (int k = 16; k >= 1; k--) begin
            issue(4'd3, 10'h0, 8'h0, 8'h0, 1'b0, 1'b0);
            chk("R11 unwind after overwrite", 32'(pc_addr), 32'(ret[k]));
        end
        issue(4'd3, 10'h0, 8'h0, 8'h0, 1'b0, 1'b0);
        chk("R11 pop past bottom circles", 32'(pc_addr), 32'(ret[16]));
    endtask

    initial begin
        t_reset();
        t_step_page();
        t_call_ret();
        t_acc_forms();
        t_irq();
        t_ring_wrap();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule